// File: doc/BRIEF.md
# Multi-view general register file

This block holds the general-purpose registers of a processor datapath and lets each operand see them at the width the instruction asks for. It has one physical store of eight 32-bit entries. The same bits can be reached as sixteen 16-bit registers, as sixteen 8-bit registers or as eight 32-bit registers. The view depends on the operand size given with each index.

There are two combinational read ports and one write port, and each port has its own index and size. A read returns the addressed operand zero-extended to 32 bits. A narrow write changes only the bytes it addresses, so the other bytes of the same 32-bit entry keep their values. Writes take effect at the rising clock edge. A read of an entry in the same cycle it is written therefore returns the old contents.

Size codes, used by every port: 0 = byte, 1 = word, 2 = longword, 3 = longword.

Top module: `gpr_views_top`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and after it is released, every entry reads as zero until it is written.
- R2: With a longword size, index bits [2:0] select entry k and index bit 3 is ignored. A read returns all 32 bits of entry k, and a write replaces all 32 bits.
- R3: With a word size, indices 0 to 7 address bits 15:0 of entry k = index, and indices 8 to 15 address bits 31:16 of entry k = index − 8.
- R4: With a byte size, index bit 3 = 0 addresses bits 15:8 and index bit 3 = 1 addresses bits 7:0 of entry index[2:0]. Bits 31:16 are never reached by a byte access.
- R5: A byte or word write leaves every other bit of the containing 32-bit entry unchanged.
- R6: A byte write stores write-data bits 7:0, and a word write stores write-data bits 15:0. The higher bits of the write data are ignored.
- R7: Byte reads return zeros in bits 31:8, and word reads return zeros in bits 31:16.
- R8: With the write enable low, no entry changes, whatever the write index, size and data are.
- R9: A read of an entry that is being written in the same cycle returns the value from before the write. The new value is visible from the cycle after the clock edge.
- R10: Both read ports work independently in the same cycle, with any mix of indices and sizes.
- R11: Size code 3 behaves exactly as longword (code 2) for reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low; clears all entries |
| rdIdxA | input | 4 | Register index for read port A |
| rdSizeA | input | 2 | Operand size for read port A |
| rdIdxB | input | 4 | Register index for read port B |
| rdSizeB | input | 2 | Operand size for read port B |
| wrEn | input | 1 | Write enable |
| wrIdx | input | 4 | Register index for the write port |
| wrSize | input | 2 | Operand size for the write port |
| wrData | input | 32 | Write data; narrow writes use the low bits |
| rdDataA | output | 32 | Zero-extended read data, port A |
| rdDataB | output | 32 | Zero-extended read data, port B |

## Verification
A write and a read can meet in the same cycle, and both of them can address the same 32-bit entry, possibly through different views. The bench provokes this by having a port read the entry that the write port targets in that cycle. Sometimes the read uses the same size, and sometimes it reaches the entry through another view, for example a longword read during a byte write. The scoreboard expects the pre-write contents in that cycle and the merged contents in the next one, and a randomized phase repeats the collision many times over mixed sizes.

// File: rtl/gpr_views_pkg.sv
package gpr_views_pkg;
  localparam int BYTE_W   = 8;
  localparam int HALF_W   = 2 * BYTE_W;
  localparam int LONG_W   = 2 * HALF_W;
  localparam int NUM_LONG = 8;
  localparam int IDX_W    = $clog2(2 * NUM_LONG);
  localparam int SEL_W    = $clog2(NUM_LONG);
  localparam int LANES    = LONG_W / BYTE_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_ALT  = 2'd3
  } opSize_e;

  // strobes from write control to the datapath
  typedef struct packed {
    logic [NUM_LONG-1:0] regHit;
    logic [LANES-1:0]    laneEn;
    logic [LONG_W-1:0]   laneData;
  } wrStrobe_t;

  function automatic logic [LONG_W-1:0] readView(
    input logic [LONG_W-1:0] entry,
    input opSize_e           sz,
    input logic              upper
  );
    logic [LONG_W-1:0] res;
    res = '0;
    unique case (sz)
      SZ_BYTE: res[BYTE_W-1:0] = upper ? entry[BYTE_W-1:0] : entry[HALF_W-1:BYTE_W];
      SZ_WORD: res[HALF_W-1:0] = upper ? entry[LONG_W-1:HALF_W] : entry[HALF_W-1:0];
      default: res = entry;
    endcase
    return res;
  endfunction
endpackage

// File: rtl/gpr_write_ctrl.sv
module gpr_write_ctrl
  import gpr_views_pkg::*;
(
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  opSize_e           wrSize,
  input  logic [LONG_W-1:0] wrData,
  output wrStrobe_t         strobe
);
  logic [SEL_W-1:0] entrySel;
  logic             upperHalf;

  assign entrySel  = wrIdx[SEL_W-1:0];
  assign upperHalf = wrIdx[SEL_W];

  always_comb begin
    strobe = '0;
    for (int k = 0; k < NUM_LONG; k++) begin
      strobe.regHit[k] = wrEn && (entrySel == SEL_W'(k));
    end
    unique case (wrSize)
      SZ_BYTE: begin
        // bit 3 set: low byte of R; clear: high byte of R
        strobe.laneEn   = upperHalf ? LANES'(1) : LANES'(2);
        strobe.laneData = {LANES{wrData[BYTE_W-1:0]}};
      end
      SZ_WORD: begin
        strobe.laneEn   = upperHalf ? LANES'(12) : LANES'(3);
        strobe.laneData = {(LONG_W/HALF_W){wrData[HALF_W-1:0]}};
      end
      default: begin
        strobe.laneEn   = '1;
        strobe.laneData = wrData;
      end
    endcase
  end
endmodule

// File: rtl/gpr_bank_dp.sv
module gpr_bank_dp
  import gpr_views_pkg::*;
#(
  parameter int NUM_RD = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strobe,
  input  logic [IDX_W-1:0]  rdIdx  [NUM_RD],
  input  opSize_e           rdSize [NUM_RD],
  output logic [LONG_W-1:0] rdData [NUM_RD]
);
  logic [LONG_W-1:0] bank [NUM_LONG];

  for (genvar k = 0; k < NUM_LONG; k++) begin : g_entry
    for (genvar b = 0; b < LANES; b++) begin : g_lane
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          bank[k][b*BYTE_W +: BYTE_W] <= '0;
        end else if (strobe.regHit[k] && strobe.laneEn[b]) begin
          bank[k][b*BYTE_W +: BYTE_W] <= strobe.laneData[b*BYTE_W +: BYTE_W];
        end
      end
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rdData[p] = readView(bank[rdIdx[p][SEL_W-1:0]], rdSize[p], rdIdx[p][SEL_W]);
  end
endmodule

// File: rtl/gpr_views_top.sv
module gpr_views_top
  import gpr_views_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic [1:0]        rdSizeA,
  input  logic [IDX_W-1:0]  rdIdxB,
  input  logic [1:0]        rdSizeB,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [1:0]        wrSize,
  input  logic [LONG_W-1:0] wrData,
  output logic [LONG_W-1:0] rdDataA,
  output logic [LONG_W-1:0] rdDataB
);
  localparam int NUM_RD = 2;

  wrStrobe_t         strobe;
  logic [IDX_W-1:0]  rdIdx  [NUM_RD];
  opSize_e           rdSize [NUM_RD];
  logic [LONG_W-1:0] rdData [NUM_RD];

  assign rdIdx[0]  = rdIdxA;
  assign rdIdx[1]  = rdIdxB;
  assign rdSize[0] = opSize_e'(rdSizeA);
  assign rdSize[1] = opSize_e'(rdSizeB);
  assign rdDataA   = rdData[0];
  assign rdDataB   = rdData[1];

  gpr_write_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrIdx  (wrIdx),
    .wrSize (opSize_e'(wrSize)),
    .wrData (wrData),
    .strobe (strobe)
  );

  gpr_bank_dp #(.NUM_RD(NUM_RD)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rdIdx  (rdIdx),
    .rdSize (rdSize),
    .rdData (rdData)
  );
endmodule

// File: rtl/gpr_views_chk.sv
module gpr_views_chk (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  rdIdxA,
  input logic [1:0]  rdSizeA,
  input logic [3:0]  rdIdxB,
  input logic [1:0]  rdSizeB,
  input logic        wrEn,
  input logic [3:0]  wrIdx,
  input logic [1:0]  wrSize,
  input logic [31:0] wrData,
  input logic [31:0] rdDataA,
  input logic [31:0] rdDataB
);
  // R7
  zext_byte_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdSizeA == 2'd0) |-> (rdDataA[31:8] == '0));

  // R7
  zext_word_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdSizeA == 2'd1) |-> (rdDataA[31:16] == '0));

  // R10
  zext_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdSizeB[1] == 1'b0) |-> (rdDataB[31:16] == '0));

  // R2
  long_wr_rd_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrEn && wrSize[1]) && rdSizeA[1] && (rdIdxA[2:0] == $past(wrIdx[2:0])))
      |-> (rdDataA == $past(wrData)));

  // R2
  long_wr_rd_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrEn && wrSize[1]) && rdSizeB[1] && (rdIdxB[2:0] == $past(wrIdx[2:0])))
      |-> (rdDataB == $past(wrData)));

  // R8
  hold_no_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(wrEn) && $stable(rdIdxA) && $stable(rdSizeA)) |-> $stable(rdDataA));
endmodule

bind gpr_views_top gpr_views_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .rdIdxA  (rdIdxA),
  .rdSizeA (rdSizeA),
  .rdIdxB  (rdIdxB),
  .rdSizeB (rdSizeB),
  .wrEn    (wrEn),
  .wrIdx   (wrIdx),
  .wrSize  (wrSize),
  .wrData  (wrData),
  .rdDataA (rdDataA),
  .rdDataB (rdDataB)
);

// File: tb/gpr_views_top_bench.sv
`timescale 1ns/100ps
module gpr_views_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  rdIdxA = '0, rdIdxB = '0, wrIdx = '0;
  logic [1:0]  rdSizeA = '0, rdSizeB = '0, wrSize = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdDataA, rdDataB;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] expA;
    logic [31:0] expB;
    string       req;
  } item_t;
  item_t sbq[$];

  logic [31:0] mdl [8];

  always #2.5 clk = ~clk;

  gpr_views_top u_gpr_views_top (
    .clk(clk), .rstN(rstN),
    .rdIdxA(rdIdxA), .rdSizeA(rdSizeA),
    .rdIdxB(rdIdxB), .rdSizeB(rdSizeB),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrSize(wrSize), .wrData(wrData),
    .rdDataA(rdDataA), .rdDataB(rdDataB)
  );

  function automatic logic [31:0] mRead(input logic [3:0] idx, input logic [1:0] sz);
    logic [31:0] v;
    v = mdl[idx[2:0]];
    case (sz)
      2'd0:    return idx[3] ? {24'h0, v[7:0]}  : {24'h0, v[15:8]};
      2'd1:    return idx[3] ? {16'h0, v[31:16]} : {16'h0, v[15:0]};
      default: return v;
    endcase
  endfunction

  task automatic mWrite(input logic [3:0] idx, input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'd0: if (idx[3]) mdl[idx[2:0]][7:0] = d[7:0]; else mdl[idx[2:0]][15:8] = d[7:0];
      2'd1: if (idx[3]) mdl[idx[2:0]][31:16] = d[15:0]; else mdl[idx[2:0]][15:0] = d[15:0];
      default: mdl[idx[2:0]] = d;
    endcase
  endtask

  // driver: one cycle of stimulus, expected read values pushed to the scoreboard
  task automatic doOp(input logic [3:0] iA, input logic [1:0] sA,
                      input logic [3:0] iB, input logic [1:0] sB,
                      input logic we, input logic [3:0] wi, input logic [1:0] ws,
                      input logic [31:0] wd, input string req);
    item_t it;
    @(negedge clk);
    rdIdxA = iA; rdSizeA = sA; rdIdxB = iB; rdSizeB = sB;
    wrEn = we; wrIdx = wi; wrSize = ws; wrData = wd;
    it.expA = mRead(iA, sA);
    it.expB = mRead(iB, sB);
    it.req  = req;
    sbq.push_back(it);
    if (we && rstN) mWrite(wi, ws, wd);
  endtask

  // monitor: compare after inputs settle, away from the rising edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() > 0) begin
        it = sbq.pop_front();
        total++;
        if (rdDataA !== it.expA) begin
          bad++;
          $display("FAIL %s port A: actual=%h expected=%h", it.req, rdDataA, it.expA);
        end
        total++;
        if (rdDataB !== it.expB) begin
          bad++;
          $display("FAIL %s port B: actual=%h expected=%h", it.req, rdDataB, it.expB);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) mdl[k] = '0;
    // R1: reset state, a write attempt during reset has no effect
    doOp(4'd0, 2'd2, 4'd7, 2'd2, 1'b1, 4'd0, 2'd2, 32'hDEAD_BEEF, "R1");
    doOp(4'd15, 2'd1, 4'd9, 2'd0, 1'b0, 4'd0, 2'd0, 32'h0, "R1");
    @(negedge clk);
    rstN = 1'b1;
    doOp(4'd0, 2'd2, 4'd4, 2'd3, 1'b0, 4'd0, 2'd0, 32'h0, "R1");
    // R2: longword write, bit 3 of the index ignored on read and write
    doOp(4'd3, 2'd2, 4'd3, 2'd2, 1'b1, 4'd3, 2'd2, 32'hA1B2_C3D4, "R2");
    doOp(4'd3, 2'd2, 4'd11, 2'd2, 1'b1, 4'd14, 2'd2, 32'h0BAD_F00D, "R2");
    doOp(4'd6, 2'd2, 4'd14, 2'd2, 1'b0, 4'd0, 2'd0, 32'h0, "R2");
    // R3, R7: word views of entry 3
    doOp(4'd3, 2'd1, 4'd11, 2'd1, 1'b0, 4'd0, 2'd0, 32'h0, "R3");
    // R4, R7: byte views of entry 3 (high byte of R, low byte of R)
    doOp(4'd3, 2'd0, 4'd11, 2'd0, 1'b0, 4'd0, 2'd0, 32'h0, "R4");
    // R5, R6: byte write low byte, upper data bits ignored
    doOp(4'd3, 2'd2, 4'd11, 2'd0, 1'b1, 4'd11, 2'd0, 32'hFFFF_FF5A, "R5");
    doOp(4'd3, 2'd2, 4'd3, 2'd0, 1'b1, 4'd3, 2'd0, 32'h1234_5677, "R6");
    // R5, R6: word write into the extended half
    doOp(4'd3, 2'd2, 4'd11, 2'd1, 1'b1, 4'd11, 2'd1, 32'h1234_9999, "R5");
    doOp(4'd3, 2'd2, 4'd11, 2'd1, 1'b0, 4'd0, 2'd0, 32'h0, "R6");
    // R8: write enable low
    doOp(4'd3, 2'd2, 4'd6, 2'd2, 1'b0, 4'd3, 2'd2, 32'h5555_5555, "R8");
    doOp(4'd3, 2'd2, 4'd6, 2'd2, 1'b0, 4'd6, 2'd0, 32'h0, "R8");
    // R9: read during write of the same entry, through several views
    doOp(4'd5, 2'd2, 4'd13, 2'd1, 1'b1, 4'd5, 2'd2, 32'hCAFE_1234, "R9");
    doOp(4'd5, 2'd2, 4'd13, 2'd0, 1'b1, 4'd13, 2'd0, 32'h0000_00EE, "R9");
    doOp(4'd5, 2'd2, 4'd5, 2'd0, 1'b0, 4'd0, 2'd0, 32'h0, "R9");
    // R10: independent ports, mixed sizes
    doOp(4'd14, 2'd0, 4'd3, 2'd1, 1'b0, 4'd0, 2'd0, 32'h0, "R10");
    // R11: size code 3 as longword
    doOp(4'd1, 2'd3, 4'd9, 2'd2, 1'b1, 4'd9, 2'd3, 32'h7654_3210, "R11");
    doOp(4'd1, 2'd3, 4'd9, 2'd3, 1'b0, 4'd0, 2'd0, 32'h0, "R11");
    // randomized mix, collisions included
    for (int n = 0; n < 400; n++) begin
      logic [3:0] wi;
      wi = 4'($urandom_range(0, 15));
      doOp((n % 3 == 0) ? wi : 4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)),
           4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), wi, 2'($urandom_range(0, 3)),
           $urandom(), "R5 R9 R10");
    end
    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule